// File: doc/BRIEF.md
# Wake-Up Capable Asynchronous Serial Receiver

This block receives asynchronous serial characters and hands them to the surrounding logic through a holding register and a set of flags. A sample enable at sixteen times the bit rate drives it. The input is the external receive pin, passed through a synchronizer, or, when loopback is selected, the internal transmit stream. Each character has a start bit, eight or nine data bits sent LSB first, and one stop bit. When parity checking is on, the last data bit is taken as the parity bit and checked for even or odd parity. The block reports data ready, overrun, idle line, framing error and parity error. It raises a receive interrupt request and an idle interrupt request, each gated by its own enable.

The receiver can be put to sleep. While it sleeps, incoming characters are discarded and the idle flag is held off. It wakes either when it detects an idle line or when a character arrives whose last data bit is set, which marks it as an address. Idle detection has two modes. In the short mode, the count of consecutive ones starts at the first one, even one inside a character. In the long mode, the count starts only after the stop bit.

The frame engine is a four-state machine: HUNT waits for a low sample. START checks that the line is still low at mid-bit. If it is not, the START-to-HUNT transition rejects the glitch; otherwise the START-to-DATA transition follows at the end of the bit. DATA takes one majority-voted bit per bit period. The DATA-to-STOP transition follows the last data bit. STOP votes the stop bit and takes the STOP-to-HUNT transition at mid-bit, so that a following start edge is not missed.

Top module: `uart_wake_rx`

## Requirements
- R1: In 8-bit mode (`nine_bits`=0), a character with data byte D sets `rdrf` and places D in `rx_data[7:0]` with `rx_data[8]`=0; a one-cycle `rd_ack` clears `rdrf`.
- R2: In 9-bit mode (`nine_bits`=1), all nine data bits, received LSB first, appear in `rx_data[8:0]`.
- R3: With `par_en`=1, `par_err` is set when the XOR of all received data bits (parity bit included, which is the last data bit) differs from `par_odd`; `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. With `par_en`=0, `par_err` stays 0.
- R4: A stop bit voted low sets `frame_err`. A stop bit voted high leaves it clear. The character is still loaded.
- R5: A character that completes while `rdrf` is 1 sets `overrun` and leaves `rx_data` unchanged. `rd_ack` clears both `rdrf` and `overrun`. `overrun` is never 1 while `rdrf` is 0.
- R6: `rx_irq` equals (`rdrf` OR `overrun`) AND `rie`. `idle_irq` equals `idle_flag` AND `ilie`.
- R7: Short idle mode (`long_idle`=0): after a start bit has been seen, `idle_flag` sets once the line has been high for 10 bit times (11 when `nine_bits`=1), counted from the first high sample, even one inside a character. `idle_clr` clears it.
- R8: Long idle mode (`long_idle`=1): the same count starts only once the stop bit has been sampled, so ones inside the character do not count.
- R9: With `wake_addr`=0, a `sleep_req` pulse sets `asleep`. Characters received while asleep leave `rdrf` and `rx_data` untouched. The idle detection ends sleep without setting `idle_flag`.
- R10: With `wake_addr`=1, a sleeping receiver discards characters whose last data bit (bit 8 in 9-bit mode, bit 7 in 8-bit mode) is 0, and it keeps `idle_flag` at 0. A character whose last data bit is 1 clears `asleep` and is loaded normally.
- R11: With `loop_en`=1, the receiver takes `loop_data` and ignores `rxd`.
- R12: A low pulse on the line that has ended before the mid-bit sample of the start bit does not start a character.
- R13: After reset, all flags and interrupt requests are 0 and `asleep` is 0. A line that has never carried a start bit never sets `idle_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable at 16x bit rate |
| rxd | input | 1 | External serial input (asynchronous) |
| loop_en | input | 1 | Select internal loopback stream |
| loop_data | input | 1 | Internal transmit stream for loopback |
| nine_bits | input | 1 | 0: 8 data bits, 1: 9 data bits |
| par_en | input | 1 | Enable parity check |
| par_odd | input | 1 | 0: even, 1: odd parity |
| long_idle | input | 1 | 0: short idle count, 1: long idle count |
| wake_addr | input | 1 | 0: wake on idle, 1: wake on address mark |
| rie | input | 1 | Receive interrupt enable |
| ilie | input | 1 | Idle interrupt enable |
| sleep_req | input | 1 | Pulse: put the receiver to sleep |
| rd_ack | input | 1 | Pulse: data consumed, clears rdrf and overrun |
| idle_clr | input | 1 | Pulse: clear idle flag |
| rx_data | output | 9 | Received data |
| rdrf | output | 1 | Receive data register full |
| overrun | output | 1 | Character lost while full |
| idle_flag | output | 1 | Idle line detected |
| frame_err | output | 1 | Stop bit sampled low |
| par_err | output | 1 | Parity mismatch |
| asleep | output | 1 | Receiver in wake-up sleep |
| rx_irq | output | 1 | Receive interrupt request |
| idle_irq | output | 1 | Idle interrupt request |

## Verification
A frame engine out of step with the line shows at the ports within one character. It produces a wrong bit pattern in `rx_data`, a spurious `frame_err`, or an `rdrf` that never rises about 160 clock cycles after the start edge. An idle counter that starts at the wrong point shifts the rise of `idle_flag` by several bit times. The bench therefore samples `idle_flag` at points where the short and long modes must disagree. A sleep state that is stuck or wrongly cleared shows as a character that is accepted or lost. The bench checks `asleep` and `rdrf` after every character in both wake schemes.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [8:0] data;
        logic       ferr;
        logic       perr;
    } rx_frame_t;

endpackage

// File: rtl/uwr_line_in.sv
module uwr_line_in #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic loop_en,
    input  logic loop_data,
    output logic line
);
    logic [SYNC-1:0] chain;
    logic            raw;

    assign raw = loop_en ? loop_data : rxd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC-2:0], raw};
    end

    assign line = chain[SYNC-1];
endmodule

// File: rtl/uwr_frame_fsm.sv
module uwr_frame_fsm
    import uwr_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line,
    input  logic      nine_bits,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      hunting,
    output logic      start_seen,
    output logic      done,
    output rx_frame_t frame
);
    localparam int PW = $clog2(OVS);
    localparam logic [PW-1:0] MID  = PW'(OVS/2 - 1);
    localparam logic [PW-1:0] V0   = PW'(OVS/2 - 2);
    localparam logic [PW-1:0] V2   = PW'(OVS/2);
    localparam logic [PW-1:0] LAST = PW'(OVS - 1);

    rx_state_t     state, nxt;
    logic [PW-1:0] ph;
    logic [3:0]    bidx;
    logic [3:0]    last_idx;
    logic [8:0]    sh;
    logic [8:0]    word;
    logic          s_a, s_b, vote;

    assign last_idx = nine_bits ? 4'd8 : 4'd7;
    assign vote     = (s_a & s_b) | (s_a & line) | (s_b & line);
    assign word     = nine_bits ? sh : {1'b0, sh[7:0]};
    assign hunting  = (state == ST_HUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:  if (tick && !line) nxt = ST_START;
            ST_START: begin
                if (tick && ph == MID && line) nxt = ST_HUNT;
                else if (tick && ph == LAST)   nxt = ST_DATA;
            end
            ST_DATA:  if (tick && ph == LAST && bidx == last_idx) nxt = ST_STOP;
            ST_STOP:  if (tick && ph == V2) nxt = ST_HUNT;
            default:  nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph         <= '0;
            bidx       <= '0;
            sh         <= '0;
            s_a        <= 1'b1;
            s_b        <= 1'b1;
            done       <= 1'b0;
            start_seen <= 1'b0;
            frame      <= '0;
        end else begin
            done       <= 1'b0;
            start_seen <= 1'b0;
            if (tick) begin
                if (state == ST_HUNT) begin
                    ph   <= PW'(1);
                    bidx <= '0;
                    if (!line) begin
                        start_seen <= 1'b1;
                        sh         <= '0;
                    end
                end else begin
                    ph <= (ph == LAST) ? '0 : ph + PW'(1);
                    if (ph == V0)  s_a <= line;
                    if (ph == MID) s_b <= line;
                    if (state == ST_DATA && ph == V2)   sh[bidx] <= vote;
                    if (state == ST_DATA && ph == LAST) bidx <= bidx + 4'd1;
                    if (state == ST_STOP && ph == V2) begin
                        done       <= 1'b1;
                        frame.data <= word;
                        frame.ferr <= ~vote;
                        frame.perr <= par_en & ((^word) != par_odd);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uwr_idle_det.sv
module uwr_idle_det #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic hunting,
    input  logic start_seen,
    input  logic long_mode,
    input  logic nine_bits,
    output logic idle_hit
);
    localparam int LIM10 = 10 * OVS;
    localparam int LIM11 = 11 * OVS;
    localparam int CW    = $clog2(LIM11 + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          armed;

    assign lim = nine_bits ? CW'(LIM11 - 1) : CW'(LIM10 - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            armed    <= 1'b0;
            idle_hit <= 1'b0;
        end else begin
            idle_hit <= 1'b0;
            if (start_seen) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (tick) begin
                if (!line) begin
                    cnt <= '0;
                end else if (armed && (!long_mode || hunting)) begin
                    if (cnt == lim) begin
                        idle_hit <= 1'b1;
                        armed    <= 1'b0;
                        cnt      <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uwr_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       loop_en,
    input  logic       loop_data,
    input  logic       nine_bits,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       long_idle,
    input  logic       wake_addr,
    input  logic       rie,
    input  logic       ilie,
    input  logic       sleep_req,
    input  logic       rd_ack,
    input  logic       idle_clr,
    output logic [8:0] rx_data,
    output logic       rdrf,
    output logic       overrun,
    output logic       idle_flag,
    output logic       frame_err,
    output logic       par_err,
    output logic       asleep,
    output logic       rx_irq,
    output logic       idle_irq
);
    logic      line, hunting, start_seen, done, idle_hit;
    rx_frame_t frame;
    logic      addr_mark, accept, wake, idle_set;

    uwr_line_in #(.SYNC(SYNC)) u_line (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .loop_en(loop_en), .loop_data(loop_data), .line(line)
    );

    uwr_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line),
        .nine_bits(nine_bits), .par_en(par_en), .par_odd(par_odd),
        .hunting(hunting), .start_seen(start_seen), .done(done), .frame(frame)
    );

    uwr_idle_det #(.OVS(OVS)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line),
        .hunting(hunting), .start_seen(start_seen),
        .long_mode(long_idle), .nine_bits(nine_bits), .idle_hit(idle_hit)
    );

    assign addr_mark = nine_bits ? frame.data[8] : frame.data[7];
    assign accept    = done & (~asleep | (wake_addr & addr_mark));
    assign wake      = asleep & ((~wake_addr & idle_hit) | (wake_addr & done & addr_mark));
    assign idle_set  = idle_hit & ~asleep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rdrf      <= 1'b0;
            overrun   <= 1'b0;
            idle_flag <= 1'b0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
            asleep    <= 1'b0;
        end else begin
            if (rd_ack) begin
                rdrf    <= 1'b0;
                overrun <= 1'b0;
            end
            if (accept) begin
                if (rdrf && !rd_ack) begin
                    overrun <= 1'b1;
                end else begin
                    rx_data   <= frame.data;
                    frame_err <= frame.ferr;
                    par_err   <= frame.perr;
                    rdrf      <= 1'b1;
                end
            end
            if (idle_clr)  idle_flag <= 1'b0;
            if (idle_set)  idle_flag <= 1'b1;
            if (wake)      asleep    <= 1'b0;
            if (sleep_req) asleep    <= 1'b1;
        end
    end

    assign rx_irq   = (rdrf | overrun) & rie;
    assign idle_irq = idle_flag & ilie;
endmodule

// File: rtl/uwr_chk.sv
module uwr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [8:0] rx_data,
    input logic       rdrf,
    input logic       overrun,
    input logic       idle_flag,
    input logic       asleep,
    input logic       wake_addr,
    input logic       rie,
    input logic       rx_irq
);
    // R5
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(rx_data));

    // R5
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> rdrf);

    // R9
    sleep_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !wake_addr) |=> !$rose(rdrf));

    // R9
    sleep_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> !$rose(idle_flag));

    // R6
    rx_irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rie |-> !rx_irq);
endmodule

bind uart_wake_rx uwr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rdrf(rdrf),
    .overrun(overrun), .idle_flag(idle_flag), .asleep(asleep),
    .wake_addr(wake_addr), .rie(rie), .rx_irq(rx_irq)
);

// File: tb/uart_wake_rx_test.sv
module uart_wake_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b1;
    logic rxd = 1'b1, loop_en = 1'b0, loop_data = 1'b1;
    logic nine_bits = 1'b0, par_en = 1'b0, par_odd = 1'b0, long_idle = 1'b0;
    logic wake_addr = 1'b0, rie = 1'b0, ilie = 1'b0;
    logic sleep_req = 1'b0, rd_ack = 1'b0, idle_clr = 1'b0;
    logic [8:0] rx_data;
    logic rdrf, overrun, idle_flag, frame_err, par_err, asleep, rx_irq, idle_irq;

    int  n_chk = 0, n_bad = 0;
    bit  via_loop = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    uart_wake_rx uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .loop_en(loop_en), .loop_data(loop_data), .nine_bits(nine_bits),
        .par_en(par_en), .par_odd(par_odd), .long_idle(long_idle),
        .wake_addr(wake_addr), .rie(rie), .ilie(ilie), .sleep_req(sleep_req),
        .rd_ack(rd_ack), .idle_clr(idle_clr), .rx_data(rx_data), .rdrf(rdrf),
        .overrun(overrun), .idle_flag(idle_flag), .frame_err(frame_err),
        .par_err(par_err), .asleep(asleep), .rx_irq(rx_irq), .idle_irq(idle_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_line(input logic b);
        if (via_loop) loop_data = b;
        else          rxd = b;
    endtask

    task automatic send(input logic [8:0] v, input int nb, input logic stop_v);
        put_line(1'b0);
        wait_n(16);
        for (int i = 0; i < nb; i++) begin
            put_line(v[i]);
            wait_n(16);
        end
        put_line(stop_v);
        wait_n(16);
        put_line(1'b1);
        wait_n(2);
    endtask

    task automatic pulse_rd();
        rd_ack = 1'b1; wait_n(1); rd_ack = 1'b0; wait_n(1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rxd = 1'b1; loop_en = 1'b0; loop_data = 1'b1; via_loop = 1'b0;
        nine_bits = 1'b0; par_en = 1'b0; par_odd = 1'b0; long_idle = 1'b0;
        wake_addr = 1'b0; rie = 1'b0; ilie = 1'b0;
        sleep_req = 1'b0; rd_ack = 1'b0; idle_clr = 1'b0;
        wait_n(4); rst_n = 1'b1; wait_n(4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R13: reset state and no idle without a prior start bit
        chk({rdrf, overrun, idle_flag, frame_err, par_err, asleep, rx_irq, idle_irq} == 8'h00,
            "R13 reset flags", {rdrf, overrun, idle_flag, asleep}, 0);
        wait_n(400);
        chk(idle_flag == 1'b0, "R13 no idle before activity", idle_flag, 0);

        // R1: exhaustive 8-bit sweep
        for (int v = 0; v < 256; v++) begin
            send(9'(v), 8, 1'b1);
            chk(rdrf == 1'b1, "R1 rdrf set", rdrf, 1);
            chk(rx_data == 9'(v) && !frame_err && !par_err, "R1 data", rx_data, v);
            pulse_rd();
        end
        chk(rdrf == 1'b0, "R1 rdrf cleared by rd_ack", rdrf, 0);

        // R2: 9-bit mode sweep
        nine_bits = 1'b1;
        for (int i = 0; i < 64; i++) begin
            logic [8:0] w;
            w = 9'((i * 37 + (i % 2) * 256) % 512);
            send(w, 9, 1'b1);
            chk(rx_data == w && rdrf, "R2 nine-bit data", rx_data, w);
            pulse_rd();
        end

        // R3: parity check, even and odd
        par_en = 1'b1;
        for (int po = 0; po < 2; po++) begin
            par_odd = po[0];
            for (int i = 0; i < 64; i++) begin
                logic [8:0] w;
                logic exp_pe;
                w = 9'((i * 53 + 7) % 512);
                exp_pe = ((^w) != po[0]);
                send(w, 9, 1'b1);
                chk(par_err == exp_pe && rx_data == w, "R3 parity", par_err, exp_pe);
                pulse_rd();
            end
        end
        par_en = 1'b0;
        send(9'h001, 9, 1'b1);
        chk(par_err == 1'b0, "R3 parity disabled", par_err, 0);
        pulse_rd();
        nine_bits = 1'b0;

        // R4: framing error
        send(9'h033, 8, 1'b0);
        wait_n(20);
        chk(frame_err == 1'b1 && rdrf && rx_data == 9'h033, "R4 stop low", frame_err, 1);
        pulse_rd();
        send(9'h034, 8, 1'b1);
        chk(frame_err == 1'b0, "R4 stop high", frame_err, 0);
        pulse_rd();

        // R5, R6: overrun and receive interrupt gating
        do_reset();
        rie = 1'b1;
        send(9'h011, 8, 1'b1);
        chk(rx_irq == 1'b1, "R6 rx_irq on rdrf", rx_irq, 1);
        send(9'h022, 8, 1'b1);
        chk(overrun == 1'b1 && rx_data == 9'h011, "R5 overrun keeps data", rx_data, 9'h011);
        rie = 1'b0; wait_n(1);
        chk(rx_irq == 1'b0, "R6 rx_irq masked", rx_irq, 0);
        pulse_rd();
        chk(!rdrf && !overrun, "R5 rd_ack clears", {rdrf, overrun}, 0);

        // R7: short idle counts ones inside the character
        do_reset();
        send(9'h0F0, 8, 1'b1);
        chk(idle_flag == 1'b0, "R7 no idle yet", idle_flag, 0);
        wait_n(110);
        chk(idle_flag == 1'b1, "R7 short idle early", idle_flag, 1);
        ilie = 1'b1; wait_n(1);
        chk(idle_irq == 1'b1, "R6 idle_irq", idle_irq, 1);
        idle_clr = 1'b1; wait_n(1); idle_clr = 1'b0; wait_n(1);
        chk(idle_flag == 1'b0 && idle_irq == 1'b0, "R7 idle_clr", idle_flag, 0);

        // R8: long idle starts after the stop bit
        do_reset();
        long_idle = 1'b1;
        send(9'h0F0, 8, 1'b1);
        wait_n(110);
        chk(idle_flag == 1'b0, "R8 long idle not yet", idle_flag, 0);
        wait_n(72);
        chk(idle_flag == 1'b1, "R8 long idle set", idle_flag, 1);

        // R9: sleep, wake on idle
        do_reset();
        sleep_req = 1'b1; wait_n(1); sleep_req = 1'b0; wait_n(1);
        send(9'h03C, 8, 1'b1);
        chk(rdrf == 1'b0 && asleep == 1'b1, "R9 frame ignored asleep", rdrf, 0);
        wait_n(200);
        chk(asleep == 1'b0 && idle_flag == 1'b0, "R9 woke on idle", {asleep, idle_flag}, 0);
        send(9'h05A, 8, 1'b1);
        chk(rdrf && rx_data == 9'h05A, "R9 receives after wake", rx_data, 9'h05A);

        // R10: sleep, wake on address mark
        do_reset();
        nine_bits = 1'b1; wake_addr = 1'b1;
        sleep_req = 1'b1; wait_n(1); sleep_req = 1'b0; wait_n(1);
        send(9'h0AA, 9, 1'b1);
        chk(rdrf == 1'b0 && asleep == 1'b1, "R10 non-address ignored", {rdrf, asleep}, 1);
        wait_n(250);
        chk(idle_flag == 1'b0 && asleep == 1'b1, "R10 idle inhibited", {idle_flag, asleep}, 1);
        send(9'h155, 9, 1'b1);
        chk(asleep == 1'b0 && rdrf && rx_data == 9'h155, "R10 address wakes", rx_data, 9'h155);

        // R11: loopback ignores rxd
        do_reset();
        loop_en = 1'b1; wait_n(1);
        rxd = 1'b0; via_loop = 1'b1;
        send(9'h0A5, 8, 1'b1);
        chk(rdrf && rx_data == 9'h0A5, "R11 loopback data", rx_data, 9'h0A5);
        via_loop = 1'b0;

        // R12: short low pulse rejected
        do_reset();
        rxd = 1'b0; wait_n(4); rxd = 1'b1;
        wait_n(400);
        chk(rdrf == 1'b0, "R12 glitch rejected", rdrf, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule